// File: doc/BRIEF.md
# Parallel Leg Shoot-Through Detector

This block watches the gate commands of up to four half-bridge legs that share one phase node and one DC bus. Legs in parallel can short the supply across each other. This happens when the upper switch of one leg and the lower switch of a different leg conduct together, even if every leg on its own is driven in a complementary way. The block measures how long each such cross-leg condition has lasted and raises a violation once the condition outlasts a programmable overlap allowance.

Gate inputs pass through a two-stage synchroniser and are normalised by one shared polarity select before any checking. Each ordered pair of distinct legs, upper of one and lower of another, has its own overlap counter. A leg-count input sets how many legs are in use. The violation output is sticky until a clear pulse. It comes with the indices of the first offending upper leg and lower leg. The gate inputs are level signals sampled every clock, so they carry no valid/ready handshake and the block never applies back-pressure. All pins are plain control and status.

Top module: `xleg_shoot_guard`

## Requirements
- R1: While reset is asserted and right after it, `viol` is 0 and both `viol_hi_leg` and `viol_lo_leg` are 0.
- R2: An upper gate on in leg i together with a lower gate on in leg j, where i differs from j, is a violation. This holds even when every leg is complementary on its own (upper on and lower off, or the reverse).
- R3: Upper and lower gates of the same leg on together never raise `viol` in this block.
- R4: Only legs with index below `leg_count` take part, and the gates of the other legs have no effect. A `leg_count` of 0 disables detection. Values above the number of legs enable all legs.
- R5: Let L be the effective allowance. A cross-leg condition raises `viol` only if it is present for at least L+1 consecutive samples. Any sample without it restarts the count from zero.
- R6: The allowance is `ovl_limit` clamped to 800 ticks, which is 5 us at 6.25 ns per tick. Any larger value acts as 800.
- R7: With an allowance of 0, a single-sample cross-leg condition raises `viol`.
- R8: When `gate_act_low` is 0, a gate bit of 1 means on. When it is 1, a gate bit of 0 means on. The select applies to every gate input.
- R9: If the condition is first present at the input on clock edge n, `viol` reads 1 after edge n+2+L and reads 0 after edge n+1+L.
- R10: `viol` stays 1 until `clr` is sampled high. `clr` takes priority over a trip in the same cycle. If the condition is still beyond the allowance, `viol` returns one cycle after `clr` drops.
- R11: `viol_hi_leg` and `viol_lo_leg` hold the first offending pair and do not change until `clr`. When several pairs trip together, the lowest upper index wins, and then the lowest lower index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per gate sample |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_act_low | input | 1 | Gate polarity select: 1 means a low level is on |
| leg_count | input | 3 | Number of legs in use (0 to 7; values above 4 mean 4) |
| ovl_limit | input | 10 | Allowed cross-leg overlap in ticks, clamped to 800 |
| gate_hi | input | 4 | Upper switch gate of each leg, bit k = leg k |
| gate_lo | input | 4 | Lower switch gate of each leg, bit k = leg k |
| clr | input | 1 | Clears the sticky violation and the latched indices |
| viol | output | 1 | Sticky cross-leg shoot-through flag |
| viol_hi_leg | output | 2 | Upper-leg index of the first violation |
| viol_lo_leg | output | 2 | Lower-leg index of the first violation |

## Verification
A pair counter that fails to clear on a broken condition shows up as a flag from a stutter pattern that should pass. A counter that misses its allowance moves the rising edge of `viol` by a cycle, which the exact-latency check at edge n+2+L catches. A wrong leg mask or polarity leaves a false flag or a missing flag within three cycles of the stimulus. A wrong priority or latch-update rule shows up at once in the index outputs after simultaneous pairs or after a second, later pair.

// File: rtl/xleg_pkg.sv
package xleg_pkg;
  localparam int unsigned XLEG_LEGS_DEF    = 4;
  localparam int unsigned XLEG_OVL_MAX_DEF = 800;

  function automatic int unsigned xleg_idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xleg_gate_sync.sv
module xleg_gate_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_low,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] on_out
);
  logic [W-1:0] norm;
  logic [W-1:0] stage1;

  // fold polarity in before the flops so both stages hold "on" levels
  assign norm = raw_in ^ {W{act_low}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      on_out <= '0;
    end else begin
      stage1 <= norm;
      on_out <= stage1;
    end
  end
endmodule

// File: rtl/xleg_pair_timer.sv
module xleg_pair_timer #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned OVL_MAX = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond,
  input  logic [CNT_W-1:0] lim,
  output logic             trip
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!cond) begin
      cnt <= '0;
    end else if (cnt < lim) begin
      cnt <= cnt + 1'b1;
    end
  end

  // cnt equals the number of earlier consecutive samples with cond set
  assign trip = cond && (cnt >= lim);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(OVL_MAX)); // R6
endmodule

// File: rtl/xleg_first_latch.sv
module xleg_first_latch #(
  parameter int unsigned N_LEGS = 4,
  parameter int unsigned IDX_W  = 2,
  localparam int unsigned NP    = N_LEGS * N_LEGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NP-1:0]    pair_trip,
  output logic             viol,
  output logic [IDX_W-1:0] hi_leg,
  output logic [IDX_W-1:0] lo_leg
);
  logic             any_trip;
  logic [IDX_W-1:0] sel_hi;
  logic [IDX_W-1:0] sel_lo;

  assign any_trip = |pair_trip;

  // scan from the top so the lowest upper index, then lowest lower index, wins
  always_comb begin
    sel_hi = '0;
    sel_lo = '0;
    for (int i = N_LEGS - 1; i >= 0; i--) begin
      for (int j = N_LEGS - 1; j >= 0; j--) begin
        if (pair_trip[i*N_LEGS + j]) begin
          sel_hi = IDX_W'(i);
          sel_lo = IDX_W'(j);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol   <= 1'b0;
      hi_leg <= '0;
      lo_leg <= '0;
    end else if (clr) begin
      viol   <= 1'b0;
      hi_leg <= '0;
      lo_leg <= '0;
    end else if (!viol && any_trip) begin
      viol   <= 1'b1;
      hi_leg <= sel_hi;
      lo_leg <= sel_lo;
    end
  end

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clr) |=> viol); // R10
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clr) |=> ($stable(hi_leg) && $stable(lo_leg))); // R11
  AST_DISTINCT_LEGS: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (hi_leg != lo_leg)); // R3
endmodule

// File: rtl/xleg_shoot_guard.sv
module xleg_shoot_guard
  import xleg_pkg::*;
#(
  parameter int unsigned N_LEGS  = XLEG_LEGS_DEF,
  parameter int unsigned OVL_MAX = XLEG_OVL_MAX_DEF,
  parameter int unsigned OVL_W   = 10,
  localparam int unsigned LC_W   = $clog2(N_LEGS + 1),
  localparam int unsigned IDX_W  = xleg_idx_bits(N_LEGS),
  localparam int unsigned CNT_W  = $clog2(OVL_MAX + 1),
  localparam int unsigned NP     = N_LEGS * N_LEGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_act_low,
  input  logic [LC_W-1:0]   leg_count,
  input  logic [OVL_W-1:0]  ovl_limit,
  input  logic [N_LEGS-1:0] gate_hi,
  input  logic [N_LEGS-1:0] gate_lo,
  input  logic              clr,
  output logic              viol,
  output logic [IDX_W-1:0]  viol_hi_leg,
  output logic [IDX_W-1:0]  viol_lo_leg
);
  logic [2*N_LEGS-1:0] raw_gates;
  logic [2*N_LEGS-1:0] on_gates;
  logic [N_LEGS-1:0]   s_hi;
  logic [N_LEGS-1:0]   s_lo;
  logic [N_LEGS-1:0]   leg_en;
  logic [CNT_W-1:0]    lim_eff;
  logic [NP-1:0]       pair_trip;

  assign raw_gates = {gate_lo, gate_hi};

  xleg_gate_sync #(.W(2*N_LEGS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_low (gate_act_low),
    .raw_in  (raw_gates),
    .on_out  (on_gates)
  );

  assign s_hi = on_gates[N_LEGS-1:0];
  assign s_lo = on_gates[2*N_LEGS-1:N_LEGS];

  always_comb begin
    for (int k = 0; k < N_LEGS; k++) begin
      leg_en[k] = (LC_W'(k) < leg_count);
    end
  end

  assign lim_eff = (ovl_limit > OVL_W'(OVL_MAX)) ? CNT_W'(OVL_MAX)
                                                  : CNT_W'(ovl_limit);

  for (genvar gi = 0; gi < N_LEGS; gi++) begin : g_up
    for (genvar gj = 0; gj < N_LEGS; gj++) begin : g_dn
      if (gi != gj) begin : g_pair
        logic cond;
        assign cond = s_hi[gi] & s_lo[gj] & leg_en[gi] & leg_en[gj];
        xleg_pair_timer #(.CNT_W(CNT_W), .OVL_MAX(OVL_MAX)) u_timer (
          .clk   (clk),
          .rst_n (rst_n),
          .cond  (cond),
          .lim   (lim_eff),
          .trip  (pair_trip[gi*N_LEGS + gj])
        );
      end else begin : g_self
        assign pair_trip[gi*N_LEGS + gj] = 1'b0;
      end
    end
  end

  xleg_first_latch #(.N_LEGS(N_LEGS), .IDX_W(IDX_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .pair_trip (pair_trip),
    .viol      (viol),
    .hi_leg    (viol_hi_leg),
    .lo_leg    (viol_lo_leg)
  );

  AST_RISE_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol) |-> $past(|pair_trip)); // R2
endmodule

// File: tb/xleg_shoot_guard_tb.sv
module xleg_shoot_guard_tb_top;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_act_low = 1'b0;
  logic [2:0] leg_count = 3'd4;
  logic [9:0] ovl_limit = '0;
  logic [3:0] gate_hi = '0;
  logic [3:0] gate_lo = '0;
  logic       clr = 1'b0;
  logic       viol;
  logic [1:0] viol_hi_leg;
  logic [1:0] viol_lo_leg;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  xleg_shoot_guard dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_act_low (gate_act_low),
    .leg_count    (leg_count),
    .ovl_limit    (ovl_limit),
    .gate_hi      (gate_hi),
    .gate_lo      (gate_lo),
    .clr          (clr),
    .viol         (viol),
    .viol_hi_leg  (viol_hi_leg),
    .viol_lo_leg  (viol_lo_leg)
  );

  typedef struct packed {
    logic       al;
    logic [2:0] lc;
    logic [9:0] lim;
    logic [3:0] hi;
    logic [3:0] lo;
    logic [11:0] hold;
    logic       ev;
    logic [1:0] eh;
    logic [1:0] el;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b0, 3'd4, 10'd0, 4'b0001, 4'b0010, 12'd1, 1'b1, 2'd0, 2'd1}, // R7 R2
    '{1'b0, 3'd4, 10'd0, 4'b0001, 4'b0001, 12'd5, 1'b0, 2'd0, 2'd0}, // R3
    '{1'b0, 3'd4, 10'd5, 4'b0100, 4'b0001, 12'd5, 1'b0, 2'd0, 2'd0}, // R5 at allowance
    '{1'b0, 3'd4, 10'd5, 4'b0100, 4'b0001, 12'd6, 1'b1, 2'd2, 2'd0}, // R5 beyond
    '{1'b1, 3'd4, 10'd0, 4'b1000, 4'b0010, 12'd1, 1'b1, 2'd3, 2'd1}, // R8 active low
    '{1'b0, 3'd2, 10'd0, 4'b0100, 4'b0001, 12'd3, 1'b0, 2'd0, 2'd0}, // R4 unused leg
    '{1'b0, 3'd2, 10'd0, 4'b0010, 4'b0001, 12'd1, 1'b1, 2'd1, 2'd0}, // R4 used legs
    '{1'b0, 3'd0, 10'd0, 4'b1111, 4'b1111, 12'd3, 1'b0, 2'd0, 2'd0}, // R4 none
    '{1'b0, 3'd7, 10'd0, 4'b1000, 4'b0100, 12'd1, 1'b1, 2'd3, 2'd2}, // R4 over range
    '{1'b0, 3'd4, 10'd0, 4'b1010, 4'b0101, 12'd1, 1'b1, 2'd1, 2'd0}, // R11 priority
    '{1'b0, 3'd4, 10'd2, 4'b0110, 4'b1001, 12'd3, 1'b1, 2'd1, 2'd0}  // R2 complementary legs
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] h, input logic [3:0] l);
    gate_hi = h ^ {N{gate_act_low}};
    gate_lo = l ^ {N{gate_act_low}};
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++;
      total++;
      $display("FAIL watchdog got=%0d exp=%0d", cycles, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 viol in reset", int'(viol), 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 viol after reset", int'(viol), 0);
    chk("R1 hi index", int'(viol_hi_leg), 0);
    chk("R1 lo index", int'(viol_lo_leg), 0);

    for (int v = 0; v < NV; v++) begin
      gate_act_low = VT[v].al;
      leg_count = VT[v].lc;
      ovl_limit = VT[v].lim;
      drive(4'b0000, 4'b0000);
      tick(4);
      clear_flag();
      drive(VT[v].hi, VT[v].lo);
      tick(int'(VT[v].hold));
      drive(4'b0000, 4'b0000);
      tick(5);
      chk($sformatf("vector %0d viol", v), int'(viol), int'(VT[v].ev));
      if (VT[v].ev) begin
        chk($sformatf("vector %0d hi", v), int'(viol_hi_leg), int'(VT[v].eh));
        chk($sformatf("vector %0d lo", v), int'(viol_lo_leg), int'(VT[v].el));
      end
    end

    // R9 exact latency with allowance 3
    gate_act_low = 1'b0;
    leg_count = 3'd4;
    ovl_limit = 10'd3;
    drive(4'b0000, 4'b0000);
    tick(4);
    clear_flag();
    drive(4'b0001, 4'b0010);
    tick(5);
    chk("R9 low at edge n+1+L", int'(viol), 0);
    tick(1);
    chk("R9 high at edge n+2+L", int'(viol), 1);

    // R10 clear wins, flag returns while condition persists
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk("R10 cleared", int'(viol), 0);
    tick(1);
    chk("R10 returns", int'(viol), 1);
    drive(4'b0000, 4'b0000);
    tick(5);
    chk("R10 sticky after release", int'(viol), 1);

    // R11 a later pair does not replace the first
    drive(4'b1000, 4'b0100);
    tick(6);
    drive(4'b0000, 4'b0000);
    tick(4);
    chk("R11 hi kept", int'(viol_hi_leg), 0);
    chk("R11 lo kept", int'(viol_lo_leg), 1);
    clear_flag();
    tick(1);
    chk("R10 clear idle", int'(viol), 0);
    chk("R11 hi cleared", int'(viol_hi_leg), 0);

    // R5 a one-sample break restarts the count
    ovl_limit = 10'd4;
    drive(4'b0001, 4'b0010);
    tick(4);
    drive(4'b0000, 4'b0000);
    tick(1);
    drive(4'b0001, 4'b0010);
    tick(4);
    drive(4'b0000, 4'b0000);
    tick(5);
    chk("R5 break restarts", int'(viol), 0);

    // R6 clamp to 800
    ovl_limit = 10'd1000;
    clear_flag();
    drive(4'b0010, 4'b0001);
    tick(800);
    drive(4'b0000, 4'b0000);
    tick(5);
    chk("R6 800 samples tolerated", int'(viol), 0);
    clear_flag();
    drive(4'b0010, 4'b0001);
    tick(801);
    drive(4'b0000, 4'b0000);
    tick(5);
    chk("R6 801 samples flagged", int'(viol), 1);
    chk("R6 hi index", int'(viol_hi_leg), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule